// File: doc/BRIEF.md
# AGP Master Status and Request Sequencer

This block is the bus-master half of an accelerated graphics port agent. Every rising clock edge it samples the three-bit status code that the chipset arbiter drives, but only while the active-low grant input is low. It turns the code into one-cycle event pulses: a low-priority read return (which also covers flush data), a high-priority read return, a demand for low-priority write data, a demand for high-priority write data, and permission to start a transaction.

When permission arrives, the block takes pending read addresses from a small internal request FIFO. A request-type input sampled in the permission cycle picks the kind of transfer. The block either streams pipelined read requests, one full-width address per clock with the active-low pipe strobe held low, or it opens a conventional PCI cycle by pulling frame low for a single address phase.

The block also drives the active-low read-buffer-full throttle. It compares the free space reported for the local low-priority read buffer against a threshold. It raises a protocol-error pulse if the arbiter returns low-priority read data while that throttle is asserted.

Top module: `agp_master_seq`

## Requirements
- R1: While `rst_n` is low, every event output and `proto_err` and `ad_oe` are 0, `pipe_n`, `frame_n` and `rbf_n` are 1, and `rq_full` is 0.
- R2: When `gnt_n` is 1 at a clock edge, the status code is ignored: after that edge no event pulse is high and no pipe or frame transfer is started.
- R3: With `gnt_n` low, code 000 sampled at an edge makes `ev_lp_rd` high for the following cycle, and code 001 does the same for `ev_hp_rd`. At most one event output is high in any cycle.
- R4: With `gnt_n` low, code 010 makes `ev_lp_wr` high for the following cycle, and code 011 does the same for `ev_hp_wr`.
- R5: Codes 100, 101 and 110 produce no event, no transfer and no error.
- R6: Code 111 with `gnt_n` low makes `ev_perm` high for the following cycle. If `req_pci` is 0 and the FIFO holds entries, `pipe_n` goes low after that edge and `ad_out` shows one queued address per cycle, oldest first, with `ad_oe` high.
- R7: `pipe_n` returns high in the cycle after the last queued address was shown, or after the first edge at which permission (grant low with code 111) is no longer sampled.
- R8: If `req_pci` is 1 at a permission edge taken from idle with entries queued, `frame_n` is low for exactly one cycle with the oldest address on `ad_out`. `pipe_n` and `frame_n` are never low together.
- R9: `rbf_n` is registered: it is 0 in the cycle after an edge at which `lp_free` < `RBF_THRESH`, and 1 after an edge at which `lp_free` >= `RBF_THRESH`.
- R10: `proto_err` pulses for one cycle after an edge at which code 000 is decoded while `rbf_n` is 0. A high-priority return (001) under the same condition raises no error.
- R11: The FIFO holds `RQ_DEPTH` addresses. `rq_full` is 1 while it is full, and an `enq_valid` push while full is dropped and never appears on `ad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt_n | input | 1 | Active-low grant from the arbiter, qualifies `st` |
| st | input | 3 | Arbiter status code |
| req_pci | input | 1 | 1 selects a PCI cycle, 0 selects pipelined requests |
| enq_valid | input | 1 | Push `enq_addr` into the request FIFO |
| enq_addr | input | ADDR_W | Read address to queue |
| lp_free | input | FREE_W | Free entries in the low-priority read buffer |
| rq_full | output | 1 | Request FIFO is full |
| ev_lp_rd | output | 1 | Low-priority read/flush data returning |
| ev_hp_rd | output | 1 | High-priority read data returning |
| ev_lp_wr | output | 1 | Low-priority write data demanded |
| ev_hp_wr | output | 1 | High-priority write data demanded |
| ev_perm | output | 1 | Permission to start a transaction |
| pipe_n | output | 1 | Active-low pipelined request strobe |
| frame_n | output | 1 | Active-low PCI frame |
| ad_out | output | ADDR_W | Address driven onto the address/data bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| rbf_n | output | 1 | Active-low read-buffer-full throttle |
| proto_err | output | 1 | Low-priority return seen while throttled |

## Verification
The assertions take only two things for granted about the inputs. The status code and grant must hold stable values at each rising edge, and `lp_free` must be a plain count that nothing else interprets. They assume nothing about which codes arrive, so reserved codes and grant-high cycles are legal stimulus. The stimulus drives every input half a period away from the active edge. It draws grant, codes, request type, pushes and free space at random, with permission weighted up so that long pipe bursts happen, and it adds directed runs for each code, FIFO overflow, withdrawal in mid-burst and a return that breaks the throttle.

// File: rtl/agp_seq_pkg.sv
package agp_seq_pkg;

  // decoded one-cycle events
  typedef struct packed {
    logic lp_rd;
    logic hp_rd;
    logic lp_wr;
    logic hp_wr;
    logic perm;
  } evt_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_PIPE, SQ_FRAME} seq_e;

  // status decode, qualified by active-low grant
  function automatic evt_t decode_status(input logic gnt_n, input logic [2:0] code);
    evt_t e;
    e = '0;
    if (!gnt_n) begin
      case (code)
        3'b000:  e.lp_rd = 1'b1;
        3'b001:  e.hp_rd = 1'b1;
        3'b010:  e.lp_wr = 1'b1;
        3'b011:  e.hp_wr = 1'b1;
        3'b111:  e.perm  = 1'b1;
        default: e = '0;
      endcase
    end
    return e;
  endfunction

  // throttle is needed when free space drops under the threshold
  function automatic logic rbf_needed(input int unsigned free_cnt, input int unsigned thr);
    return free_cnt < thr;
  endfunction

endpackage

// File: rtl/agp_stat_decode.sv
module agp_stat_decode
  import agp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gnt_n,
  input  logic [2:0] st,
  output evt_t       now_ev,
  output evt_t       ev_q
);

  assign now_ev = decode_status(gnt_n, st);

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= now_ev;
  end

  // R2
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_n |=> (ev_q == '0));

  // R5
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_n && st[2] && (st != 3'b111)) |=> (ev_q == '0));

  // R3
  event_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_q));

endmodule

// File: rtl/agp_req_fifo.sv
module agp_req_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && (wr_ptr == AW'(i))) mem[i] <= din;
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/agp_rbf_ctl.sv
module agp_rbf_ctl
  import agp_seq_pkg::*;
#(
  parameter int FREE_W = 6,
  parameter int THRESH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] lp_free,
  output logic              rbf_n
);

  always_ff @(posedge clk) begin
    if (!rst_n) rbf_n <= 1'b1;
    else        rbf_n <= !rbf_needed(32'(lp_free), 32'(THRESH));
  end

  // R9
  rbf_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lp_free) >= 32'(THRESH)) |=> rbf_n);

endmodule

// File: rtl/agp_master_seq.sv
module agp_master_seq
  import agp_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RQ_DEPTH   = 4,
  parameter int FREE_W     = 6,
  parameter int RBF_THRESH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_n,
  input  logic [2:0]        st,
  input  logic              req_pci,
  input  logic              enq_valid,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [FREE_W-1:0] lp_free,
  output logic              rq_full,
  output logic              ev_lp_rd,
  output logic              ev_hp_rd,
  output logic              ev_lp_wr,
  output logic              ev_hp_wr,
  output logic              ev_perm,
  output logic              pipe_n,
  output logic              frame_n,
  output logic [ADDR_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              rbf_n,
  output logic              proto_err
);

  evt_t              now_ev, ev_q;
  seq_e              sq;
  logic              fifo_empty, fifo_full, go;
  logic [ADDR_W-1:0] fifo_head, ad_q;
  logic              perr_q;

  agp_stat_decode u_dec (
    .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .st(st),
    .now_ev(now_ev), .ev_q(ev_q)
  );

  agp_req_fifo #(.DEPTH(RQ_DEPTH), .W(ADDR_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(enq_valid), .din(enq_addr),
    .pop(go), .dout(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  agp_rbf_ctl #(.FREE_W(FREE_W), .THRESH(RBF_THRESH)) u_rbf (
    .clk(clk), .rst_n(rst_n), .lp_free(lp_free), .rbf_n(rbf_n)
  );

  // a new address is issued when permission holds and work is queued
  assign go = (sq != SQ_FRAME) && now_ev.perm && !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq     <= SQ_IDLE;
      ad_q   <= '0;
      perr_q <= 1'b0;
    end else begin
      perr_q <= now_ev.lp_rd && !rbf_n;
      if (go) begin
        ad_q <= fifo_head;
        sq   <= (sq == SQ_IDLE && req_pci) ? SQ_FRAME : SQ_PIPE;
      end else begin
        sq   <= SQ_IDLE;
      end
    end
  end

  assign rq_full   = fifo_full;
  assign ev_lp_rd  = ev_q.lp_rd;
  assign ev_hp_rd  = ev_q.hp_rd;
  assign ev_lp_wr  = ev_q.lp_wr;
  assign ev_hp_wr  = ev_q.hp_wr;
  assign ev_perm   = ev_q.perm;
  assign pipe_n    = (sq != SQ_PIPE);
  assign frame_n   = (sq != SQ_FRAME);
  assign ad_oe     = (sq != SQ_IDLE);
  assign ad_out    = ad_q;
  assign proto_err = perr_q;

  // R8
  pipe_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!pipe_n && !frame_n));

  // R6
  pipe_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_n |-> $past(now_ev.perm));

  // R8
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> frame_n);

  // R10
  err_when_throttled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(!rbf_n && now_ev.lp_rd));

endmodule

// File: tb/sim_agp_master_seq.sv
`timescale 1ns/1ps
module sim_agp_master_seq;

  localparam int AW = 32;
  localparam int DEPTH = 4;
  localparam int FW = 6;
  localparam int THR = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt_n = 1'b1;
  logic [2:0] st = 3'b000;
  logic req_pci = 1'b0;
  logic enq_valid = 1'b0;
  logic [AW-1:0] enq_addr = '0;
  logic [FW-1:0] lp_free = 6'd40;
  logic rq_full, ev_lp_rd, ev_hp_rd, ev_lp_wr, ev_hp_wr, ev_perm;
  logic pipe_n, frame_n, ad_oe, rbf_n, proto_err;
  logic [AW-1:0] ad_out;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [4:0] m_ev = '0;      // {lp_rd, hp_rd, lp_wr, hp_wr, perm}
  int m_sq = 0;               // 0 idle, 1 pipe, 2 frame
  logic [AW-1:0] m_ad = '0;
  logic m_rbf_n = 1'b1;
  logic m_perr = 1'b0;
  logic [AW-1:0] q[$];

  always #4 clk = ~clk;

  agp_master_seq #(.ADDR_W(AW), .RQ_DEPTH(DEPTH), .FREE_W(FW), .RBF_THRESH(THR)) u0 (
    .clk(clk), .rst_n(rst_n), .gnt_n(gnt_n), .st(st), .req_pci(req_pci),
    .enq_valid(enq_valid), .enq_addr(enq_addr), .lp_free(lp_free),
    .rq_full(rq_full), .ev_lp_rd(ev_lp_rd), .ev_hp_rd(ev_hp_rd),
    .ev_lp_wr(ev_lp_wr), .ev_hp_wr(ev_hp_wr), .ev_perm(ev_perm),
    .pipe_n(pipe_n), .frame_n(frame_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .rbf_n(rbf_n), .proto_err(proto_err)
  );

  function automatic logic [4:0] bench_code(input logic g_n, input logic [2:0] c);
    if (g_n) return 5'b0;
    if (c == 3'd0) return 5'b10000;
    if (c == 3'd1) return 5'b01000;
    if (c == 3'd2) return 5'b00100;
    if (c == 3'd3) return 5'b00010;
    if (c == 3'd7) return 5'b00001;
    return 5'b0;
  endfunction

  task automatic model_step();
    logic [4:0] ne;
    bit go, full_pre;
    ne = bench_code(gnt_n, st);
    go = (m_sq != 2) && ne[0] && (q.size() > 0);
    full_pre = (q.size() == DEPTH);
    m_perr = ne[4] && !m_rbf_n;
    if (go) begin
      m_ad = q.pop_front();
      m_sq = (m_sq == 0 && req_pci) ? 2 : 1;
    end else begin
      m_sq = 0;
    end
    if (enq_valid && !full_pre) q.push_back(enq_addr);
    m_rbf_n = (int'(lp_free) >= THR);
    m_ev = ne;
  endtask

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "ev_lp_rd", 32'(ev_lp_rd), 32'(m_ev[4]));
    chk(tag, "ev_hp_rd", 32'(ev_hp_rd), 32'(m_ev[3]));
    chk(tag, "ev_lp_wr", 32'(ev_lp_wr), 32'(m_ev[2]));
    chk(tag, "ev_hp_wr", 32'(ev_hp_wr), 32'(m_ev[1]));
    chk(tag, "ev_perm", 32'(ev_perm), 32'(m_ev[0]));
    chk(tag, "pipe_n", 32'(pipe_n), 32'(m_sq != 1));
    chk(tag, "frame_n", 32'(frame_n), 32'(m_sq != 2));
    chk(tag, "ad_oe", 32'(ad_oe), 32'(m_sq != 0));
    if (m_sq != 0) chk(tag, "ad_out", ad_out, m_ad);
    chk(tag, "rbf_n", 32'(rbf_n), 32'(m_rbf_n));
    chk(tag, "proto_err", 32'(proto_err), 32'(m_perr));
    chk(tag, "rq_full", 32'(rq_full), 32'(q.size() == DEPTH));
  endtask

  // inputs are set at a falling edge before calling
  task automatic cyc(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic status(input string tag, input logic g_n, input logic [2:0] c);
    gnt_n = g_n; st = c;
    cyc(tag);
  endtask

  task automatic push(input string tag, input logic [AW-1:0] a);
    enq_valid = 1'b1; enq_addr = a;
    cyc(tag);
    enq_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: outputs inactive under reset
    compare("R1");
    rst_n = 1'b1;

    // R2: grant high masks every code, even with work queued
    push("R2", 32'h1000_0001);
    for (int c = 0; c < 8; c++) status("R2", 1'b1, 3'(c));

    // R3 and R4: each event code with grant low
    status("R3", 1'b0, 3'b000);
    status("R3", 1'b0, 3'b001);
    status("R4", 1'b0, 3'b010);
    status("R4", 1'b0, 3'b011);
    // R5: reserved codes
    status("R5", 1'b0, 3'b100);
    status("R5", 1'b0, 3'b101);
    status("R5", 1'b0, 3'b110);

    // R6 / R7: burst drains queue, then pipe rises
    push("R6", 32'h1000_0002);
    push("R6", 32'h1000_0003);
    req_pci = 1'b0;
    for (int i = 0; i < 5; i++) status("R6", 1'b0, 3'b111);
    status("R7", 1'b1, 3'b000);

    // R7: permission withdrawn mid-burst
    for (int i = 0; i < 3; i++) push("R7", 32'h2000_0000 + 32'(i));
    status("R7", 1'b0, 3'b111);
    status("R7", 1'b0, 3'b111);
    status("R7", 1'b0, 3'b000);
    status("R7", 1'b1, 3'b000);

    // R8: conventional cycle, one address per permission from idle
    req_pci = 1'b1;
    status("R8", 1'b0, 3'b111);
    status("R8", 1'b0, 3'b111);
    status("R8", 1'b0, 3'b111);
    status("R8", 1'b1, 3'b111);
    req_pci = 1'b0;

    // R9: threshold edges
    lp_free = 6'(THR);     status("R9", 1'b1, 3'b000);
    lp_free = 6'(THR - 1); status("R9", 1'b1, 3'b000);
    lp_free = 6'd0;        status("R9", 1'b1, 3'b000);
    lp_free = 6'(THR);     status("R9", 1'b1, 3'b000);

    // R10: low-priority return while throttled
    lp_free = 6'd1;  status("R10", 1'b1, 3'b000);
    status("R10", 1'b0, 3'b001);
    status("R10", 1'b0, 3'b000);
    lp_free = 6'd50; status("R10", 1'b0, 3'b000);
    status("R10", 1'b0, 3'b000);

    // R11: overflow drops extra pushes
    status("R11", 1'b1, 3'b000);
    for (int i = 0; i < DEPTH + 2; i++) push("R11", 32'h3000_0000 + 32'(i));
    for (int i = 0; i < DEPTH + 2; i++) status("R11", 1'b0, 3'b111);
    status("R11", 1'b1, 3'b000);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      gnt_n     = ($urandom % 5) == 0;
      st        = (($urandom % 3) == 0) ? 3'b111 : 3'($urandom);
      req_pci   = ($urandom % 4) == 0;
      enq_valid = ($urandom % 2) == 0;
      enq_addr  = $urandom;
      lp_free   = 6'($urandom % 20);
      cyc("RND");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule